// File: doc/BRIEF.md
# In-Circuit Test Mode Controller

This block governs the board-test behaviour of a chip's output pads. A dedicated active-low test input (`tmode_n`) puts every functional output into high impedance while it is held low, so a bed-of-nails tester can drive the board nets without contention. The same pin also acts as a strobe. On its rising edge the controller captures an 8-bit command from a shared code bus, together with two qualifier inputs. A qualified command can switch on a NAND-tree continuity chain, and a second command switches it off again.

While the chain is on, it drives a dedicated test output pad. The chain is a serial string of NAND stages over a parameter-selected subset of monitored input pins, so a tester can see each input solder joint by toggling pins and watching one output. Pads are modelled as data/enable pairs. All asynchronous test inputs are brought into the clock domain through a multi-stage synchronizer before any decision is taken.

Top module: `ict_mode_ctrl`

## Requirements
- R1: Three clock edges after `tmode_n` goes low, and for as long as it stays low, every bit of `pad_oe` is 0. `pad_d` always equals `func_d`.
- R2: The code bus and the qualifiers are captured once per rising edge of `tmode_n`. Holding `tmode_n` high while the bus changes captures nothing.
- R3: A capture counts only when `sel_lo` is 0 and `sel_hi` is 1 at the rising edge. Any other qualifier pattern leaves the tree state unchanged.
- R4: A qualified capture of code 8'hA5 turns the tree on.
- R5: A qualified capture of code 8'h5A turns the tree off.
- R6: A qualified capture of any code other than 8'hA5 or 8'h5A leaves the tree state unchanged.
- R7: While the tree is on, `tree_oe` is 1 and `tree_d` is the last stage of a chain whose state starts at 1. For each pin i from 0 upward, when mask bit i is set the state becomes NAND(`mon_pin[i]`, state); when the bit is clear the state passes through unchanged.
- R8: While the tree is off, `tree_oe` and `tree_d` are both 0.
- R9: A monitored pin whose mask bit is clear (pin 4 under the default mask 8'hEF) has no effect on `tree_d`.
- R10: Synchronous reset turns the tree off. If `tmode_n` is high during reset, the reset also releases the high-impedance override, so `pad_oe` equals `func_oe` from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmode_n | input | 1 | Test input: low forces outputs to high impedance, rising edge captures a command |
| cfg_code | input | 8 | Shared command bus |
| sel_lo | input | 1 | Qualifier that must be 0 at capture |
| sel_hi | input | 1 | Qualifier that must be 1 at capture |
| func_d | input | N_OUT | Functional output data from the core |
| func_oe | input | N_OUT | Functional output enables from the core |
| pad_d | output | N_OUT | Data to the output pads |
| pad_oe | output | N_OUT | Enables to the output pads after the override |
| mon_pin | input | N_MON | Monitored input pins feeding the chain |
| tree_oe | output | 1 | Enable of the chain's test output pad |
| tree_d | output | 1 | Data of the chain's test output pad |

## Verification
The in-RTL properties check, on every cycle, that the synchronized strobe pulses for at most one cycle and that the tree state moves only on a qualified capture. They also check that the activate and deactivate codes set the state they name, that other codes leave it alone, and that the override flag tracks the synchronized test level. Only the bench scenarios can show the end-to-end behaviour at the ports. That covers the latency from the pin to the pad enables, the value of the chain across random pin patterns, the masked pin having no effect, and reset in the middle of a run with the tree on.

// File: rtl/ict_pkg.sv
// Shared types and helpers for the in-circuit test mode controller.
// Assumes an 8-bit command bus; the command width is fixed here.
package ict_pkg;

    localparam int CODE_W = 8;

    // Decoded effect of one captured command on the tree state
    typedef enum logic [1:0] {
        CMD_KEEP = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2
    } tree_cmd_e;

    // One sample of the asynchronous test inputs, carried as a bundle
    typedef struct packed {
        logic              lvl;   // test pin level, 1 = normal
        logic [CODE_W-1:0] code;  // command bus
        logic              lo;    // qualifier expected low
        logic              hi;    // qualifier expected high
    } ict_smp_t;

    // Map a command byte to its effect on the tree
    function automatic tree_cmd_e decode_cmd(
        input logic [CODE_W-1:0] code,
        input logic [CODE_W-1:0] act,
        input logic [CODE_W-1:0] deact
    );
        if (code == act)        return CMD_ON;
        else if (code == deact) return CMD_OFF;
        else                    return CMD_KEEP;
    endfunction

endpackage

// File: rtl/ict_in_sync.sv
// Brings the test pin, command bus and qualifiers into the clock domain
// through STAGES flops, then flags a rising edge of the synchronized pin.
// Assumes the bus and qualifiers are held steady around the pin edge for
// at least STAGES+1 cycles, so they align with the synchronized level.
module ict_in_sync
    import ict_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ict_smp_t raw,
    output ict_smp_t smp,
    output logic     rise
);

    localparam ict_smp_t RST_VAL = '{1'b1, {CODE_W{1'b0}}, 1'b0, 1'b0};

    ict_smp_t stg [STAGES];
    logic     prev_lvl;

    // Shift the input bundle through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= raw;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    // Remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b1;
        else        prev_lvl <= stg[STAGES-1].lvl;
    end

    // Present the aligned sample and its rising-edge flag
    always_comb begin
        smp  = stg[STAGES-1];
        rise = stg[STAGES-1].lvl & ~prev_lvl;
    end

    // One capture per edge: the strobe never lasts two cycles
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ict_mode_reg.sv
// Holds the tree on/off state and the high-impedance override flag.
// Assumes smp and rise come from the synchronizer; a command counts only
// on a strobe cycle with the qualifier pattern lo=0, hi=1.
module ict_mode_reg
    import ict_pkg::*;
#(
    parameter logic [CODE_W-1:0] ACT_CODE   = 8'hA5,
    parameter logic [CODE_W-1:0] DEACT_CODE = 8'h5A
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ict_smp_t smp,
    input  logic     rise,
    output logic     tree_on,
    output logic     hiz_force
);

    logic      cap_ok;
    tree_cmd_e cmd;

    // Qualify the strobe and decode the captured command
    always_comb begin
        cap_ok = rise & ~smp.lo & smp.hi;
        cmd    = cap_ok ? decode_cmd(smp.code, ACT_CODE, DEACT_CODE) : CMD_KEEP;
    end

    // Apply the decoded command to the tree state
    always_ff @(posedge clk) begin
        if (!rst_n)              tree_on <= 1'b0;
        else if (cmd == CMD_ON)  tree_on <= 1'b1;
        else if (cmd == CMD_OFF) tree_on <= 1'b0;
    end

    // Force high impedance while the synchronized test level is low
    always_ff @(posedge clk) begin
        if (!rst_n) hiz_force <= 1'b0;
        else        hiz_force <= ~smp.lvl;
    end

    p_hiz_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !smp.lvl |=> hiz_force);
    p_hiz_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp.lvl |=> !hiz_force);
    p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(tree_on));
    p_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (smp.lo || !smp.hi)) |=> $stable(tree_on));
    p_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ok && smp.code == ACT_CODE) |=> tree_on);
    p_deact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ok && smp.code == DEACT_CODE) |=> !tree_on);
    p_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ok && smp.code != ACT_CODE && smp.code != DEACT_CODE) |=> $stable(tree_on));

endmodule

// File: rtl/ict_nand_chain.sv
// Serial NAND continuity chain over the monitored pins. A stage whose mask
// bit is clear passes the previous stage through unchanged. The chain input
// is the constant 1. Output pad is driven only while enabled.
module ict_nand_chain #(
    parameter int               N    = 8,
    parameter logic [N-1:0]     MASK = '1
) (
    input  logic [N-1:0] pins,
    input  logic         enable,
    output logic         out_d,
    output logic         out_oe
);

    logic [N:0] stage;

    assign stage[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (MASK[i]) begin : g_nand
            // Active stage: NAND of this pin with the previous stage
            assign stage[i+1] = ~(pins[i] & stage[i]);
        end else begin : g_pass
            // Bypassed stage: pin is not part of the chain
            assign stage[i+1] = stage[i];
        end
    end

    // Gate the chain result onto the test pad
    always_comb begin
        out_oe = enable;
        out_d  = enable & stage[N];
    end

endmodule

// File: rtl/ict_pad_gate.sv
// Applies the high-impedance override to the functional pad enables.
// Data passes straight through; only the enables are gated.
module ict_pad_gate #(
    parameter int N = 16
) (
    input  logic [N-1:0] func_d,
    input  logic [N-1:0] func_oe,
    input  logic         hiz_force,
    output logic [N-1:0] pad_d,
    output logic [N-1:0] pad_oe
);

    for (genvar i = 0; i < N; i++) begin : g_pad
        // Per-pad override of the enable, data untouched
        assign pad_oe[i] = func_oe[i] & ~hiz_force;
        assign pad_d[i]  = func_d[i];
    end

endmodule

// File: rtl/ict_mode_ctrl.sv
// Top of the in-circuit test mode controller. It synchronizes the test
// inputs, latches the tree mode on a qualified strobe, overrides the pad
// enables and drives the NAND chain pad. Assumes pads are data/enable pairs.
module ict_mode_ctrl
    import ict_pkg::*;
#(
    parameter int                N_OUT       = 16,
    parameter int                N_MON       = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [N_MON-1:0]  MON_MASK    = 8'hEF,
    parameter logic [CODE_W-1:0] ACT_CODE    = 8'hA5,
    parameter logic [CODE_W-1:0] DEACT_CODE  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmode_n,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              sel_lo,
    input  logic              sel_hi,
    input  logic [N_OUT-1:0]  func_d,
    input  logic [N_OUT-1:0]  func_oe,
    output logic [N_OUT-1:0]  pad_d,
    output logic [N_OUT-1:0]  pad_oe,
    input  logic [N_MON-1:0]  mon_pin,
    output logic              tree_oe,
    output logic              tree_d
);

    ict_smp_t raw_smp;
    ict_smp_t sync_smp;
    logic     strobe;
    logic     tree_on;
    logic     hiz_force;

    // Bundle the asynchronous test inputs
    always_comb raw_smp = '{tmode_n, cfg_code, sel_lo, sel_hi};

    ict_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_smp),
        .smp  (sync_smp),
        .rise (strobe)
    );

    ict_mode_reg #(.ACT_CODE(ACT_CODE), .DEACT_CODE(DEACT_CODE)) mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (sync_smp),
        .rise     (strobe),
        .tree_on  (tree_on),
        .hiz_force(hiz_force)
    );

    ict_pad_gate #(.N(N_OUT)) gate_i (
        .func_d   (func_d),
        .func_oe  (func_oe),
        .hiz_force(hiz_force),
        .pad_d    (pad_d),
        .pad_oe   (pad_oe)
    );

    ict_nand_chain #(.N(N_MON), .MASK(MON_MASK)) chain_i (
        .pins  (mon_pin),
        .enable(tree_on),
        .out_d (tree_d),
        .out_oe(tree_oe)
    );

    // The tree pad is silent whenever the mode register holds it off
    p_tree_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tree_on |-> (!tree_oe && !tree_d));

endmodule

// File: tb/ict_mode_ctrl_tb.sv
// Bench for the in-circuit test mode controller: fixed-seed random command
// sequences plus directed corner cases, checked against a bench-side model.
module ict_mode_ctrl_tb_top;

    localparam int N_OUT = 16;
    localparam int N_MON = 8;
    localparam logic [N_MON-1:0] MASK = 8'hEF;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             tmode_n;
    logic [7:0]       cfg_code;
    logic             sel_lo, sel_hi;
    logic [N_OUT-1:0] func_d, func_oe, pad_d, pad_oe;
    logic [N_MON-1:0] mon_pin;
    logic             tree_oe, tree_d;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ict_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tmode_n(tmode_n), .cfg_code(cfg_code),
        .sel_lo(sel_lo), .sel_hi(sel_hi), .func_d(func_d), .func_oe(func_oe),
        .pad_d(pad_d), .pad_oe(pad_oe), .mon_pin(mon_pin),
        .tree_oe(tree_oe), .tree_d(tree_d)
    );

    // Chain value from R7: state starts at 1, masked stages NAND in
    function automatic logic chain_ref(input logic [N_MON-1:0] p);
        logic s = 1'b1;
        for (int i = 0; i < N_MON; i++) if (MASK[i]) s = ~(p[i] & s);
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare the tree pad against the model for the current pins
    task automatic check_tree(input string req);
        check(req, {31'd0, tree_oe}, {31'd0, model_on});
        check(req, {31'd0, tree_d}, {31'd0, model_on & chain_ref(mon_pin)});
    endtask

    // Low-hold then rise of the test pin with a given command and qualifiers
    task automatic strobe(input logic [7:0] code, input logic lo, input logic hi);
        tmode_n = 1'b0; cfg_code = code; sel_lo = lo; sel_hi = hi;
        func_oe = N_OUT'($urandom); func_d = N_OUT'($urandom);
        wait_cyc(6);
        check("R1 hiz while low", 32'(pad_oe), 32'd0);
        check("R1 data pass", 32'(pad_d), 32'(func_d));
        tmode_n = 1'b1;
        wait_cyc(6);
        if (!lo && hi) begin
            if (code == 8'hA5) model_on = 1'b1;
            else if (code == 8'h5A) model_on = 1'b0;
        end
        check("R1 release", 32'(pad_oe), 32'(func_oe));
        check_tree((!lo && hi) ? ((code == 8'hA5) ? "R4" : (code == 8'h5A) ? "R5" : "R6") : "R3");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] c;
        logic [N_MON-1:0] p;
        logic o0;
        void'($urandom(32'd1234));
        rst_n = 1'b0; tmode_n = 1'b1; cfg_code = 8'h00; sel_lo = 1'b0; sel_hi = 1'b1;
        func_d = '0; func_oe = '1; mon_pin = '0;
        wait_cyc(3);
        check("R10 reset tree off", {31'd0, tree_oe}, 32'd0);
        check("R10 reset pad_oe", 32'(pad_oe), 32'(func_oe));
        rst_n = 1'b1;
        wait_cyc(1);
        check("R10 after reset", 32'(pad_oe), 32'(func_oe));
        check_tree("R8 idle");

        // R2: bus change with pin held high captures nothing
        cfg_code = 8'hA5; wait_cyc(8);
        check_tree("R2 no edge");

        // R3 directed: bad qualifier patterns
        strobe(8'hA5, 1'b1, 1'b1);
        strobe(8'hA5, 1'b0, 1'b0);
        // R4 activate and R7 chain patterns
        strobe(8'hA5, 1'b0, 1'b1);
        mon_pin = '1; #1 check_tree("R7 all high");
        mon_pin = '0; #1 check_tree("R7 all low");
        // R9: masked pin 4 toggles, output unchanged
        mon_pin = 8'hFF; #1 o0 = tree_d;
        mon_pin = 8'hEF; #1 check("R9 masked pin", {31'd0, tree_d}, {31'd0, o0});
        // R2: while on, bus changes to deactivate code without an edge
        cfg_code = 8'h5A; wait_cyc(8);
        check_tree("R2 no edge while on");
        // R6 other code keeps it on
        strobe(8'h33, 1'b0, 1'b1);
        // R5 deactivate
        strobe(8'h5A, 1'b0, 1'b1);
        check_tree("R8 off");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            case ($urandom % 3)
                0: c = 8'hA5;
                1: c = 8'h5A;
                default: c = 8'($urandom);
            endcase
            strobe(c, ($urandom % 4) == 0, ($urandom % 4) != 0);
            for (int k = 0; k < 4; k++) begin
                p = N_MON'($urandom);
                mon_pin = p; #1 check_tree("R7 random pins");
                mon_pin = p ^ 8'h10; #1 check_tree("R9 random masked");
            end
        end

        // R10: reset mid-run with the tree on
        strobe(8'hA5, 1'b0, 1'b1);
        rst_n = 1'b0; model_on = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
        check_tree("R10 reset clears tree");
        check("R10 pads released", 32'(pad_oe), 32'(func_oe));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule